// File: doc/BRIEF.md
# Basic-Rate ISDN Time-Division Link Port

This block sits between a controller and a basic-rate ISDN serial time-division link. The link clock is the block's clock. A frame sync pulse, sampled on a rising edge, starts a frame of eighteen bit slots. The block splits each received frame into two 64 kbps bearer bytes and a 16 kbps signaling stream, and it builds the transmit frame from bytes that the controller supplies.

The transmit data line is driven only during the block's own slots and is left high-impedance at all other times. The block only transmits signaling bits after it has asked for the shared signaling channel with a request output and has seen a grant input. Signaling bits that are not granted are held for a later frame. On the receive side, a completed bearer byte or eight collected signaling bits appear with a one-cycle valid strobe. On the transmit side, each channel takes bytes through a valid/ready handshake.

Top module: `isdn_bri_link`

## Requirements
- R1: A high `fsync` sampled on a rising edge makes the following clock period slot 0. A frame has 18 slots in a fixed order: slots 0-7 carry B1, slot 8 carries D, slots 9-16 carry B2 and slot 17 carries D. After slot 17 the link is idle until the next sync.
- R2: In every B slot `txd_en` is 1 and `link_txd` carries the byte MSB first, with slot 0 (B1) and slot 9 (B2) carrying bit 7. Transmit bits change on the rising edge.
- R3: Outside the block's slots, and in D slots that it does not use, `txd_en` is 0 and `link_txd` is high-impedance.
- R4: `tx_b1_ready` is high in the cycle whose closing edge starts slot 0, and `tx_b2_ready` is high in the cycle whose closing edge starts slot 9. If the matching valid is high at that edge, its byte is sent. Otherwise 0xFF is sent.
- R5: `tx_d_ready` is high exactly when no signaling bits are pending, and a valid byte is then taken at that edge. `d_req` is high exactly while bits of that byte are still unsent.
- R6: A D slot carries the next pending bit (MSB first) only if `grant` is high at the edge that starts the slot and a bit is pending. Otherwise the slot is not driven and the bit is kept for a later D slot.
- R7: `rxd` is sampled on the falling edge in the middle of each slot. Levels on `rxd` outside B and D slots have no effect on any received byte.
- R8: The received B1 byte appears with `rx_b1_valid` high for one cycle during slot 8, and the received B2 byte appears with `rx_b2_valid` high for one cycle during slot 17. The first bit received lands in bit 7 of each byte.
- R9: Received D bits are collected MSB first across frames. In the cycle after the eighth bit's slot, `rx_d_valid` pulses for one cycle together with the byte.
- R10: A sync that arrives while slots 0-16 are still running restarts the frame, and `frame_err` pulses high in the next cycle. A sync at the edge that ends slot 17 raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync pulse |
| rxd | input | 1 | Serial receive data |
| grant | input | 1 | Signaling-channel grant |
| tx_b1_data | input | 8 | B1 transmit byte |
| tx_b1_valid | input | 1 | B1 transmit byte valid |
| tx_b1_ready | output | 1 | B1 byte taken at this edge |
| tx_b2_data | input | 8 | B2 transmit byte |
| tx_b2_valid | input | 1 | B2 transmit byte valid |
| tx_b2_ready | output | 1 | B2 byte taken at this edge |
| tx_d_data | input | 8 | Signaling transmit byte |
| tx_d_valid | input | 1 | Signaling transmit byte valid |
| tx_d_ready | output | 1 | Signaling buffer empty |
| rx_b1_data | output | 8 | Received B1 byte |
| rx_b1_valid | output | 1 | B1 byte strobe |
| rx_b2_data | output | 8 | Received B2 byte |
| rx_b2_valid | output | 1 | B2 byte strobe |
| rx_d_data | output | 8 | Received signaling byte |
| rx_d_valid | output | 1 | Signaling byte strobe |
| link_txd | output | 1 | Serial transmit data, high-impedance when unused |
| txd_en | output | 1 | Transmit line drive enable |
| d_req | output | 1 | Signaling-channel request |
| frame_err | output | 1 | Early-sync framing error pulse |

## Verification
The hardest case to reach is a signaling byte whose bits are spread unevenly across several frames. The grant pattern changes from one frame to the next, so some D slots are granted and others are refused. The bench loads a single signaling byte and then runs frames with grant patterns of none, only the first slot, only the second slot, and both slots. Its queue model checks each D slot for the drive enable and the bit value, and it checks when the request output drops. Frames are cut short by an early sync and also sent back to back with no gap, and the receive signaling byte has to stay aligned across all of these frame shapes.

// File: rtl/bri_pkg.sv
package bri_pkg;

    typedef enum logic [1:0] {SK_IDLE, SK_B1, SK_D, SK_B2} slot_kind_e;

    // Slot layout: [0, bw) B1, bw D, (bw, 2bw] B2, 2bw+1 D
    function automatic slot_kind_e slot_kind(input logic act, input int idx, input int bw);
        if (!act)            return SK_IDLE;
        if (idx < bw)        return SK_B1;
        if (idx == bw)       return SK_D;
        if (idx <= 2 * bw)   return SK_B2;
        return SK_D;
    endfunction

    // Bit position inside a B byte, MSB in the first slot of the channel
    function automatic int slot_bit(input int idx, input int bw);
        return (idx < bw) ? (bw - 1 - idx) : (2 * bw - idx);
    endfunction

endpackage

// File: rtl/bri_slot_timer.sv
module bri_slot_timer #(
    parameter int BYTE_W = 8,
    localparam int LAST  = 2 * BYTE_W + 1,
    localparam int CW    = $clog2(LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic          act_q,
    output logic [CW-1:0] cnt_q,
    output logic          act_d,
    output logic [CW-1:0] cnt_d,
    output logic          err_q
);
    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic          err;
    } tim_t;

    tim_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (fsync) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
            s_d.err = s_q.act && (s_q.cnt != CW'(LAST));
        end else if (s_q.act) begin
            if (s_q.cnt == CW'(LAST)) s_d.act = 1'b0;
            else                      s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_q = s_q.act;
    assign cnt_q = s_q.cnt;
    assign act_d = s_d.act;
    assign cnt_d = s_d.cnt;
    assign err_q = s_q.err;
endmodule

// File: rtl/bri_rx_demux.sv
module bri_rx_demux
    import bri_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CW    = $clog2(2 * BYTE_W + 2),
    localparam int DCW   = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_q,
    input  logic [CW-1:0]     cnt_q,
    input  logic              rx_bit,
    output logic [BYTE_W-1:0] b1_data,
    output logic              b1_valid,
    output logic [BYTE_W-1:0] b2_data,
    output logic              b2_valid,
    output logic [BYTE_W-1:0] d_data,
    output logic              d_valid
);
    typedef struct packed {
        logic [BYTE_W-1:0] b1sh;
        logic [BYTE_W-1:0] b2sh;
        logic [BYTE_W-1:0] dsh;
        logic [DCW-1:0]    dn;
        logic              b1v;
        logic              b2v;
        logic              dv;
    } rx_t;

    rx_t r_q, r_d;
    slot_kind_e kind;

    always_comb begin
        r_d     = r_q;
        r_d.b1v = 1'b0;
        r_d.b2v = 1'b0;
        r_d.dv  = 1'b0;
        kind    = slot_kind(act_q, int'(cnt_q), BYTE_W);
        case (kind)
            SK_B1: begin
                r_d.b1sh = {r_q.b1sh[BYTE_W-2:0], rx_bit};
                r_d.b1v  = (cnt_q == CW'(BYTE_W - 1));
            end
            SK_B2: begin
                r_d.b2sh = {r_q.b2sh[BYTE_W-2:0], rx_bit};
                r_d.b2v  = (cnt_q == CW'(2 * BYTE_W));
            end
            SK_D: begin
                r_d.dsh = {r_q.dsh[BYTE_W-2:0], rx_bit};
                if (r_q.dn == DCW'(BYTE_W - 1)) begin
                    r_d.dn = '0;
                    r_d.dv = 1'b1;
                end else begin
                    r_d.dn = r_q.dn + DCW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign b1_data  = r_q.b1sh;
    assign b1_valid = r_q.b1v;
    assign b2_data  = r_q.b2sh;
    assign b2_valid = r_q.b2v;
    assign d_data   = r_q.dsh;
    assign d_valid  = r_q.dv;
endmodule

// File: rtl/bri_tx_mux.sv
module bri_tx_mux
    import bri_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CW    = $clog2(2 * BYTE_W + 2),
    localparam int DCW   = $clog2(BYTE_W + 1),
    localparam int BIW   = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_d,
    input  logic [CW-1:0]     cnt_d,
    input  logic              grant,
    input  logic [BYTE_W-1:0] b1_data,
    input  logic              b1_valid,
    output logic              b1_ready,
    input  logic [BYTE_W-1:0] b2_data,
    input  logic              b2_valid,
    output logic              b2_ready,
    input  logic [BYTE_W-1:0] d_data,
    input  logic              d_valid,
    output logic              d_ready,
    output logic              req,
    output logic              txd,
    output logic              txd_en
);
    typedef struct packed {
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b2;
        logic [BYTE_W-1:0] dbuf;
        logic [DCW-1:0]    dleft;
        logic              txd;
        logic              en;
    } tx_t;

    tx_t t_q, t_d;
    slot_kind_e nk;
    logic [BIW-1:0] pos;

    always_comb begin
        t_d      = t_q;
        nk       = slot_kind(act_d, int'(cnt_d), BYTE_W);
        pos      = BIW'(slot_bit(int'(cnt_d), BYTE_W));
        b1_ready = (nk == SK_B1) && (cnt_d == '0);
        b2_ready = (nk == SK_B2) && (cnt_d == CW'(BYTE_W + 1));
        d_ready  = (t_q.dleft == '0);

        if (b1_ready) t_d.b1 = b1_valid ? b1_data : '1;
        if (b2_ready) t_d.b2 = b2_valid ? b2_data : '1;
        if (d_ready && d_valid) begin
            t_d.dbuf  = d_data;
            t_d.dleft = DCW'(BYTE_W);
        end

        t_d.en  = 1'b0;
        t_d.txd = 1'b1;
        case (nk)
            SK_B1: begin
                t_d.en  = 1'b1;
                t_d.txd = t_d.b1[pos];
            end
            SK_B2: begin
                t_d.en  = 1'b1;
                t_d.txd = t_d.b2[pos];
            end
            SK_D: begin
                if (grant && (t_q.dleft != '0)) begin
                    t_d.en    = 1'b1;
                    t_d.txd   = t_q.dbuf[BYTE_W-1];
                    t_d.dbuf  = {t_q.dbuf[BYTE_W-2:0], 1'b0};
                    t_d.dleft = t_q.dleft - DCW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{b1: '1, b2: '1, dbuf: '0, dleft: '0, txd: 1'b1, en: 1'b0};
        else        t_q <= t_d;
    end

    assign req    = (t_q.dleft != '0);
    assign txd    = t_q.txd;
    assign txd_en = t_q.en;
endmodule

// File: rtl/isdn_bri_link.sv
module isdn_bri_link #(
    parameter int BYTE_W = 8,
    localparam int CW    = $clog2(2 * BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              rxd,
    input  logic              grant,
    input  logic [BYTE_W-1:0] tx_b1_data,
    input  logic              tx_b1_valid,
    output logic              tx_b1_ready,
    input  logic [BYTE_W-1:0] tx_b2_data,
    input  logic              tx_b2_valid,
    output logic              tx_b2_ready,
    input  logic [BYTE_W-1:0] tx_d_data,
    input  logic              tx_d_valid,
    output logic              tx_d_ready,
    output logic [BYTE_W-1:0] rx_b1_data,
    output logic              rx_b1_valid,
    output logic [BYTE_W-1:0] rx_b2_data,
    output logic              rx_b2_valid,
    output logic [BYTE_W-1:0] rx_d_data,
    output logic              rx_d_valid,
    output logic              link_txd,
    output logic              txd_en,
    output logic              d_req,
    output logic              frame_err
);
    logic          slot_act_q, slot_act_d;
    logic [CW-1:0] slot_cnt_q, slot_cnt_d;
    logic          rx_s;
    logic          txd_bit;

    // receive bit captured mid-slot
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) rx_s <= 1'b0;
        else        rx_s <= rxd;
    end

    bri_slot_timer #(.BYTE_W(BYTE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .act_q (slot_act_q),
        .cnt_q (slot_cnt_q),
        .act_d (slot_act_d),
        .cnt_d (slot_cnt_d),
        .err_q (frame_err)
    );

    bri_rx_demux #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_q    (slot_act_q),
        .cnt_q    (slot_cnt_q),
        .rx_bit   (rx_s),
        .b1_data  (rx_b1_data),
        .b1_valid (rx_b1_valid),
        .b2_data  (rx_b2_data),
        .b2_valid (rx_b2_valid),
        .d_data   (rx_d_data),
        .d_valid  (rx_d_valid)
    );

    bri_tx_mux #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_d    (slot_act_d),
        .cnt_d    (slot_cnt_d),
        .grant    (grant),
        .b1_data  (tx_b1_data),
        .b1_valid (tx_b1_valid),
        .b1_ready (tx_b1_ready),
        .b2_data  (tx_b2_data),
        .b2_valid (tx_b2_valid),
        .b2_ready (tx_b2_ready),
        .d_data   (tx_d_data),
        .d_valid  (tx_d_valid),
        .d_ready  (tx_d_ready),
        .req      (d_req),
        .txd      (txd_bit),
        .txd_en   (txd_en)
    );

    assign link_txd = txd_en ? txd_bit : 1'bz;
endmodule

// File: rtl/bri_link_chk.sv
module bri_link_chk #(
    parameter int BYTE_W = 8,
    localparam int CW    = $clog2(2 * BYTE_W + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fsync,
    input logic          grant,
    input logic          d_req,
    input logic          txd_en,
    input logic          rx_b1_valid,
    input logic          rx_b2_valid,
    input logic          frame_err,
    input logic          slot_act,
    input logic [CW-1:0] slot_cnt
);
    // R10
    early_sync_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(fsync));

    // R3
    idle_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_act |-> !txd_en);

    // R6
    d_slot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_en && slot_act && (slot_cnt == CW'(BYTE_W) || slot_cnt == CW'(2 * BYTE_W + 1)))
        |-> ($past(grant) && $past(d_req)));

    // R5
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(d_req) |-> txd_en);

    // R8
    rx_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_b1_valid && rx_b2_valid));
endmodule

bind isdn_bri_link bri_link_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .grant       (grant),
    .d_req       (d_req),
    .txd_en      (txd_en),
    .rx_b1_valid (rx_b1_valid),
    .rx_b2_valid (rx_b2_valid),
    .frame_err   (frame_err),
    .slot_act    (slot_act_q),
    .slot_cnt    (slot_cnt_q)
);

// File: tb/tb_isdn_bri_link.sv
`timescale 1ns/1ps
module tb_isdn_bri_link;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0, rxd = 1'b0, grant = 1'b0;
    logic [7:0] tx_b1_data = 8'h00, tx_b2_data = 8'h00, tx_d_data = 8'h00;
    logic tx_b1_valid = 1'b0, tx_b2_valid = 1'b0, tx_d_valid = 1'b0;
    logic tx_b1_ready, tx_b2_ready, tx_d_ready;
    logic [7:0] rx_b1_data, rx_b2_data, rx_d_data;
    logic rx_b1_valid, rx_b2_valid, rx_d_valid;
    logic link_txd, txd_en, d_req, frame_err;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    bit dq[$];          // pending transmit D bits
    bit rdq[$];         // received D bits collected
    bit exp_dv = 0;  logic [7:0] exp_dbyte = 8'h00;
    bit exp_b1v = 0; logic [7:0] exp_b1 = 8'h00;
    bit exp_b2v = 0; logic [7:0] exp_b2 = 8'h00;
    bit exp_err = 0;

    always #2 clk = ~clk;

    isdn_bri_link dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .grant(grant),
        .tx_b1_data(tx_b1_data), .tx_b1_valid(tx_b1_valid), .tx_b1_ready(tx_b1_ready),
        .tx_b2_data(tx_b2_data), .tx_b2_valid(tx_b2_valid), .tx_b2_ready(tx_b2_ready),
        .tx_d_data(tx_d_data), .tx_d_valid(tx_d_valid), .tx_d_ready(tx_d_ready),
        .rx_b1_data(rx_b1_data), .rx_b1_valid(rx_b1_valid),
        .rx_b2_data(rx_b2_data), .rx_b2_valid(rx_b2_valid),
        .rx_d_data(rx_d_data), .rx_d_valid(rx_d_valid),
        .link_txd(link_txd), .txd_en(txd_en), .d_req(d_req), .frame_err(frame_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 idle, 1 B slot, 2 D slot
    task automatic tick(input int kind, input bit bbit);
        bit e_en, e_bit;
        @(posedge clk); #1;
        e_en = 0; e_bit = 0;
        if (kind == 1) begin e_en = 1; e_bit = bbit; end
        else if (kind == 2 && grant && dq.size() > 0) begin e_en = 1; e_bit = dq.pop_front(); end
        chk(kind == 2 ? "R6 d-slot enable" : "R3/R2 enable", {31'd0, txd_en}, {31'd0, e_en});
        if (e_en) chk(kind == 2 ? "R6 d bit" : "R2 b bit", {31'd0, link_txd}, {31'd0, e_bit});
        chk("R8 b1 valid", {31'd0, rx_b1_valid}, {31'd0, exp_b1v});
        if (exp_b1v) chk("R8 b1 byte", {24'd0, rx_b1_data}, {24'd0, exp_b1});
        chk("R8 b2 valid", {31'd0, rx_b2_valid}, {31'd0, exp_b2v});
        if (exp_b2v) chk("R8 b2 byte", {24'd0, rx_b2_data}, {24'd0, exp_b2});
        chk("R9 d valid", {31'd0, rx_d_valid}, {31'd0, exp_dv});
        if (exp_dv) chk("R9 d byte", {24'd0, rx_d_data}, {24'd0, exp_dbyte});
        chk("R5 req", {31'd0, d_req}, {31'd0, (dq.size() > 0)});
        chk("R10 frame_err", {31'd0, frame_err}, {31'd0, exp_err});
        exp_b1v = 0; exp_b2v = 0; exp_dv = 0; exp_err = 0;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            tick(0, 0);
            rxd = 1'($urandom);   // R7: idle-slot noise must not matter
        end
    endtask

    task automatic run_frame(input logic [7:0] t1, input bit v1, input logic [7:0] t2, input bit v2,
                             input logic [7:0] r1, input logic [7:0] r2, input logic [1:0] rd,
                             input bit g8, input bit g17, input int cut, input int ngap);
        logic [7:0] s1, s2;
        bit b;
        s1 = v1 ? t1 : 8'hFF;
        s2 = v2 ? t2 : 8'hFF;
        fsync = 1'b1;
        tx_b1_valid = v1; tx_b1_data = t1;
        tx_b2_valid = v2; tx_b2_data = t2;
        #1 chk("R4 b1 ready", {31'd0, tx_b1_ready}, 32'd1);
        for (int k = 0; k < 18; k++) begin
            grant = (k == 8) ? g8 : (k == 17) ? g17 : 1'b0;
            if (k == 9) chk("R4 b2 ready", {31'd0, tx_b2_ready}, 32'd1);
            if (k < 8)       tick(1, s1[7-k]);
            else if (k < 9)  tick(2, 0);
            else if (k < 17) tick(1, s2[16-k]);
            else             tick(2, 0);
            fsync = 1'b0;
            if (k == 0) tx_b1_valid = 1'b0;
            if (k == 9) tx_b2_valid = 1'b0;
            if (k < 8) b = r1[7-k];
            else if (k == 8) b = rd[1];
            else if (k < 17) b = r2[16-k];
            else b = rd[0];
            rxd = b;
            if (k == cut) begin
                exp_err = 1;   // R10: next frame starts early
                return;
            end
            if (k == 7) begin exp_b1v = 1; exp_b1 = r1; end
            if (k == 16) begin exp_b2v = 1; exp_b2 = r2; end
            if (k == 8 || k == 17) begin
                rdq.push_back(b);
                if (rdq.size() == 8) begin
                    exp_dv = 1;
                    for (int j = 0; j < 8; j++) exp_dbyte[7-j] = rdq[j];
                    rdq.delete();
                end
            end
        end
        grant = 1'b0;
        gap(ngap);
    endtask

    task automatic load_d(input logic [7:0] v);
        chk("R5 d ready empty", {31'd0, tx_d_ready}, 32'd1);
        tx_d_valid = 1'b1; tx_d_data = v;
        for (int j = 7; j >= 0; j--) dq.push_back(v[j]);
        tick(0, 0);
        tx_d_valid = 1'b0;
        chk("R5 d ready full", {31'd0, tx_d_ready}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R3 reset enable", {31'd0, txd_en}, 32'd0);
        chk("R5 reset req", {31'd0, d_req}, 32'd0);
        chk("R10 reset err", {31'd0, frame_err}, 32'd0);
        gap(3);
        // R2 R4 R8: plain frame, no D pending
        run_frame(8'hA5, 1, 8'h3C, 1, 8'h96, 8'h0F, 2'b10, 1, 1, -1, 4);
        load_d(8'hC3);
        // R6: both granted
        run_frame(8'h5A, 1, 8'h00, 0, 8'h81, 8'h7E, 2'b01, 1, 1, -1, 3);
        // R6: none granted, bits kept
        run_frame(8'h00, 0, 8'hF0, 1, 8'h01, 8'h80, 2'b11, 0, 0, -1, 2);
        run_frame(8'h12, 1, 8'h34, 1, 8'hFF, 8'h00, 2'b00, 1, 0, -1, 2);
        run_frame(8'h56, 1, 8'h78, 1, 8'h55, 8'hAA, 2'b10, 0, 1, -1, 5);
        // R10: early sync cuts frame at slot 4
        run_frame(8'h9A, 1, 8'hBC, 1, 8'hC0, 8'h0C, 2'b11, 1, 1, 4, 0);
        // back-to-back frames, sync right after slot 17: no error
        run_frame(8'hDE, 1, 8'hAD, 0, 8'h3E, 8'hE3, 2'b01, 1, 1, -1, 0);
        run_frame(8'hBE, 1, 8'hEF, 1, 8'h69, 8'h96, 2'b10, 1, 1, -1, 3);
        load_d(8'h5D);
        run_frame(8'h11, 0, 8'h22, 0, 8'h24, 8'h42, 2'b00, 1, 1, -1, 2);
        run_frame(8'h33, 1, 8'h44, 1, 8'h18, 8'h81, 2'b11, 1, 1, -1, 2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule